// File: doc/BRIEF.md
# UART Channel FIFO Register File

This block is the host-side half of a 16550-style serial channel. It decodes an 8-bit register bus with a 3-bit address and separate read and write strobes. It holds one 64-entry receive queue and one 64-entry transmit queue.

A serial shifter, which sits outside this block, drops each received byte into the receive queue. Each byte arrives with a one-bit error flag. The shifter takes bytes out of the transmit queue through a simple pop port. The host configures the channel and reads its state through five registers:

- **Divisor latch.** Passed to the baud generator on `baud_div`.
- **Line control.** Its low seven bits go to the shifter on `frame_cfg`.
- **Interrupt enable.** Selects which interrupt sources are allowed.
- **FIFO control / interrupt identification pair.** These share one address. A write reaches the control register and a read returns the identification register.
- **Line status.** Reports queue and error state.

Both queue resets clear themselves. The FIFO-enable state is reflected back in the identification byte, so software can confirm the mode it set.

Register reads are combinational: `host_rdata` is valid in the same cycle as `host_rd`. Read side effects (popping the receive queue, clearing the overrun flag) take place at the clock edge that ends the read cycle.

Top module: `uart_fifo_regs`

## Requirements
- R1: After reset:
  - the FIFOs are disabled, the receive trigger code is 00 and both queues are empty;
  - interrupt enable, line control and the divisor are all zero;
  - line status (address 5) reads 0x20, identification (address 2) reads 0x01, and `irq` is low.
- R2: Address 2 is direction-selected. A write updates the FIFO control register. A read always returns the identification byte and never the value that was written.
- R3: Writing address 2 with bit 1 set empties the receive queue and zeroes its count and its error tracking. The bit does not stay set, so bytes pushed later are kept. Writing bit 1 as 0 leaves the receive queue unchanged.
- R4: Writing address 2 with bit 2 set empties the transmit queue and zeroes its count. The bit self-clears, and writing it as 0 has no effect.
- R5: FIFO control bit 0 enables FIFO mode. Identification bits 7 and 6 both equal this bit and bits 5:4 read 0. With FIFO mode on and nothing pending, identification reads 0xC1.
- R6: FIFO control bits 7:6 select the receive trigger level: 00 gives 8, 01 gives 16, 10 gives 56 and 11 gives 60 bytes. When interrupt-enable bit 0 is set (address 1, non-divisor mode), a receive interrupt is pending while the receive count is at or above the level. Identification then reads 0xC4 (bits 3:1 = 010, bit 0 = 0) and `irq` is high. One byte fewer than the level leaves it unpending.
- R7: When interrupt-enable bit 1 is set and the transmit queue is empty, a transmit interrupt is pending. Identification bits 3:1 then read 001 (0xC2 in FIFO mode). A pending receive interrupt takes precedence over it. Identification bit 0 reads 0 exactly when `irq` is high.
- R8: Line status bit 0 is 1 while the receive queue holds at least one byte. Line status bit 5 is 1 while the transmit queue is empty.
- R9: Line status bit 7 is 1 while any byte still held in the receive queue was pushed with `rx_err_in` high. It drops once the last such byte is read out or the queue is cleared.
- R10: A receive push into a full queue drops the byte and sets line status bit 1. The bit stays set until line status is read.
- R11: Line control bit 7 redirects address 0 to the divisor low byte and address 1 to the divisor high byte, for both read and write. In this mode, writes to address 0 do not enter the transmit queue and reads of address 0 do not pop. Line control reads back as written, and its bits 6:0 appear on `frame_cfg`. Writing 0x03 selects 8 data bits, no parity and 1 stop bit.
- R12: A queue clear issued in the same cycle as a push or pop to that queue wins, and the count ends at zero.
- R13: With FIFO mode off, each queue holds one byte and the receive level is 1. Any write that changes FIFO control bit 0 empties both queues.
- R14: Both queues are first-in first-out. Reading address 0 (non-divisor mode) returns and removes the oldest received byte, or returns 0x00 if the queue is empty. Writing address 0 appends a transmit byte, and `tx_byte` always shows the oldest transmit byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request, high while any enabled source is pending |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_err_in | input | 1 | Reception error attached to `rx_byte` |
| tx_pop | input | 1 | Shifter takes the oldest transmit byte |
| tx_byte | output | 8 | Oldest transmit byte (0x00 when empty) |
| tx_avail | output | 1 | Transmit queue not empty |
| baud_div | output | 16 | Divisor latch value |
| frame_cfg | output | 7 | Line control bits 6:0 |

## Verification
The checker assumes the following about the inputs:
- `host_rd` and `host_wr` are never high together.
- Each register access lasts one cycle.
- `rx_push` and `tx_pop` may coincide with any host access, including a clear of the same queue.

The bench drives each host strobe for exactly one cycle, spaced by an idle cycle. It deliberately overlaps a clear with a push or a pop in one cycle to reach the precedence case. The full-queue drop property assumes the queue is at its 64-entry capacity and that no pop or control write happens in that cycle. The stimulus fills the queue to exactly that point before pushing one extra byte.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_IDFC  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LCTL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LSTAT = 3'd5;

    typedef enum logic [1:0] {
        TRIG_8  = 2'b00,
        TRIG_16 = 2'b01,
        TRIG_56 = 2'b10,
        TRIG_60 = 2'b11
    } rx_trig_e;

    typedef enum logic [2:0] {
        ID_NONE     = 3'b000,
        ID_TX_EMPTY = 3'b001,
        ID_RX_DATA  = 3'b010
    } int_id_e;

    typedef struct packed {
        logic [7:0] data;
        logic       err;
    } rx_entry_t;

    typedef struct packed {
        logic       err_any;
        logic       rsv6;
        logic       tx_empty;
        logic [2:0] rsv4_2;
        logic       overrun;
        logic       data_rdy;
    } lstat_t;

    typedef struct packed {
        logic wr_txd;
        logic wr_ien;
        logic wr_div_lo;
        logic wr_div_hi;
        logic wr_fctl;
        logic wr_lctl;
        logic rd_rxd;
        logic rd_lstat;
    } host_op_t;

    function automatic int trig_level(rx_trig_e t);
        case (t)
            TRIG_8:  return 8;
            TRIG_16: return 16;
            TRIG_56: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic logic [7:0] make_ident(logic fifo_on, int_id_e id, logic pend);
        return {fifo_on, fifo_on, 2'b00, id, ~pend};
    endfunction

endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
    import uart_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              dlab,
    output host_op_t          op
);

    always_comb begin
        op = '0;
        case (addr)
            A_DATA: begin
                op.wr_txd    = wr && !dlab;
                op.wr_div_lo = wr && dlab;
                op.rd_rxd    = rd && !dlab;
            end
            A_IEN: begin
                op.wr_ien    = wr && !dlab;
                op.wr_div_hi = wr && dlab;
            end
            A_IDFC:  op.wr_fctl  = wr;
            A_LCTL:  op.wr_lctl  = wr;
            A_LSTAT: op.rd_lstat = rd;
            default: op = '0;
        endcase
    end

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] cap,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    output logic             push_ok,
    input  logic             pop,
    output logic             pop_ok,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             full;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q >= cap);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign rdata   = mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr && !rst) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/uart_intr_ident.sv
module uart_intr_ident
    import uart_regs_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             fifo_on,
    input  logic [1:0]       ien,
    input  rx_trig_e         trig,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             tx_empty,
    output logic             irq,
    output logic [7:0]       ident
);

    logic [CNT_W-1:0] rx_level;
    logic             rx_pend;
    logic             tx_pend;
    int_id_e          id;

    assign rx_level = fifo_on ? CNT_W'(trig_level(trig)) : CNT_W'(1);
    assign rx_pend  = ien[0] && (rx_count >= rx_level);
    assign tx_pend  = ien[1] && tx_empty;
    assign irq      = rx_pend || tx_pend;

    always_comb begin
        if (rx_pend)      id = ID_RX_DATA;
        else if (tx_pend) id = ID_TX_EMPTY;
        else              id = ID_NONE;
    end

    assign ident = make_ident(fifo_on, id, irq);

endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
    import uart_regs_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  host_addr,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        irq,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    input  logic        rx_err_in,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    output logic        tx_avail,
    output logic [15:0] baud_div,
    output logic [6:0]  frame_cfg
);

    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int ENTRY_W = $bits(rx_entry_t);

    host_op_t         op;
    logic             fifo_on_q;
    rx_trig_e         trig_q;
    logic [1:0]       ien_q;
    logic [7:0]       lctl_q;
    logic [15:0]      div_q;
    logic             ovr_q;
    logic [CNT_W-1:0] err_cnt_q;

    logic             en_change;
    logic             rx_clr;
    logic             tx_clr;
    logic [CNT_W-1:0] cap;

    rx_entry_t        rx_in;
    rx_entry_t        rx_head;
    logic [ENTRY_W-1:0] rx_head_raw;
    logic             rx_push_ok;
    logic             rx_pop_ok;
    logic [CNT_W-1:0] rx_count;
    logic             rx_empty;

    logic [7:0]       tx_head;
    logic             tx_push_ok;
    logic             tx_pop_ok;
    logic [CNT_W-1:0] tx_count;
    logic             tx_empty;

    logic [7:0]       ident;
    lstat_t           lsr;

    uart_host_decode u_decode (
        .addr (host_addr),
        .rd   (host_rd),
        .wr   (host_wr),
        .dlab (lctl_q[7]),
        .op   (op)
    );

    assign en_change = op.wr_fctl && (host_wdata[0] != fifo_on_q);
    assign rx_clr    = (op.wr_fctl && host_wdata[1]) || en_change;
    assign tx_clr    = (op.wr_fctl && host_wdata[2]) || en_change;
    assign cap       = fifo_on_q ? CNT_W'(DEPTH) : CNT_W'(1);

    assign rx_in.data = rx_byte;
    assign rx_in.err  = rx_err_in;
    assign rx_head    = rx_entry_t'(rx_head_raw);

    uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W), .CNT_W(CNT_W)) u_rx_fifo (
        .clk     (clk),
        .rst     (rst),
        .clr     (rx_clr),
        .cap     (cap),
        .push    (rx_push),
        .wdata   (rx_in),
        .push_ok (rx_push_ok),
        .pop     (op.rd_rxd),
        .pop_ok  (rx_pop_ok),
        .rdata   (rx_head_raw),
        .count   (rx_count),
        .empty   (rx_empty)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8), .CNT_W(CNT_W)) u_tx_fifo (
        .clk     (clk),
        .rst     (rst),
        .clr     (tx_clr),
        .cap     (cap),
        .push    (op.wr_txd),
        .wdata   (host_wdata),
        .push_ok (tx_push_ok),
        .pop     (tx_pop),
        .pop_ok  (tx_pop_ok),
        .rdata   (tx_head),
        .count   (tx_count),
        .empty   (tx_empty)
    );

    uart_intr_ident #(.CNT_W(CNT_W)) u_ident (
        .fifo_on  (fifo_on_q),
        .ien      (ien_q),
        .trig     (trig_q),
        .rx_count (rx_count),
        .tx_empty (tx_empty),
        .irq      (irq),
        .ident    (ident)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_on_q <= 1'b0;
            trig_q    <= TRIG_8;
            ien_q     <= '0;
            lctl_q    <= '0;
            div_q     <= '0;
            ovr_q     <= 1'b0;
        end else begin
            if (op.wr_fctl) begin
                fifo_on_q <= host_wdata[0];
                trig_q    <= rx_trig_e'(host_wdata[7:6]);
            end
            if (op.wr_ien)    ien_q       <= host_wdata[1:0];
            if (op.wr_lctl)   lctl_q      <= host_wdata;
            if (op.wr_div_lo) div_q[7:0]  <= host_wdata;
            if (op.wr_div_hi) div_q[15:8] <= host_wdata;
            if (rx_push && !rx_push_ok && !rx_clr) ovr_q <= 1'b1;
            else if (op.rd_lstat)                  ovr_q <= 1'b0;
        end
    end

    // Count of errored bytes still held in the receive queue
    always_ff @(posedge clk) begin
        if (rst || rx_clr) begin
            err_cnt_q <= '0;
        end else begin
            case ({rx_push_ok && rx_err_in, rx_pop_ok && rx_head.err})
                2'b10:   err_cnt_q <= err_cnt_q + 1'b1;
                2'b01:   err_cnt_q <= err_cnt_q - 1'b1;
                default: err_cnt_q <= err_cnt_q;
            endcase
        end
    end

    always_comb begin
        lsr          = '0;
        lsr.data_rdy = !rx_empty;
        lsr.overrun  = ovr_q;
        lsr.tx_empty = tx_empty;
        lsr.err_any  = (err_cnt_q != '0);
    end

    always_comb begin
        case (host_addr)
            A_DATA:  host_rdata = lctl_q[7] ? div_q[7:0]
                                : (rx_empty ? 8'h00 : rx_head.data);
            A_IEN:   host_rdata = lctl_q[7] ? div_q[15:8] : {6'b0, ien_q};
            A_IDFC:  host_rdata = ident;
            A_LCTL:  host_rdata = lctl_q;
            A_LSTAT: host_rdata = lsr;
            default: host_rdata = 8'h00;
        endcase
    end

    assign tx_byte   = tx_empty ? 8'h00 : tx_head;
    assign tx_avail  = !tx_empty;
    assign baud_div  = div_q;
    assign frame_cfg = lctl_q[6:0];

endmodule

// File: rtl/uart_fifo_regs_chk.sv
module uart_fifo_regs_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       host_addr,
    input logic             host_rd,
    input logic             host_wr,
    input logic             fc_rx_clr,
    input logic             fc_tx_clr,
    input logic [7:0]       host_rdata,
    input logic             irq,
    input logic             rx_push,
    input logic             dlab,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] err_cnt
);

    logic fc_write;
    logic id_read;
    logic host_pop;

    assign fc_write = host_wr && (host_addr == 3'd2);
    assign id_read  = host_rd && (host_addr == 3'd2);
    assign host_pop = host_rd && (host_addr == 3'd0) && !dlab;

    a_r3_rx_clear: assert property (@(posedge clk) disable iff (rst)
        (fc_write && fc_rx_clr) |=> (rx_cnt == '0));

    a_r4_tx_clear: assert property (@(posedge clk) disable iff (rst)
        (fc_write && fc_tx_clr) |=> (tx_cnt == '0));

    a_r12_clear_beats_push: assert property (@(posedge clk) disable iff (rst)
        (fc_write && fc_rx_clr && rx_push) |=> (rx_cnt == '0 && err_cnt == '0));

    a_r5_mirror_bits: assert property (@(posedge clk) disable iff (rst)
        id_read |-> (host_rdata[7] == host_rdata[6] && host_rdata[5:4] == 2'b00));

    a_r7_irq_vs_ident: assert property (@(posedge clk) disable iff (rst)
        id_read |-> (irq == !host_rdata[0]));

    a_r7_id_when_pending: assert property (@(posedge clk) disable iff (rst)
        (id_read && !host_rdata[0]) |-> (host_rdata[3:1] != 3'b000));

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CNT_W'(DEPTH));

    a_r10_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_cnt == CNT_W'(DEPTH) && !host_pop && !fc_write)
        |=> (rx_cnt == CNT_W'(DEPTH)));

    a_r9_err_bounded: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= rx_cnt);

endmodule

bind uart_fifo_regs uart_fifo_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .fc_rx_clr  (host_wdata[1]),
    .fc_tx_clr  (host_wdata[2]),
    .host_rdata (host_rdata),
    .irq        (irq),
    .rx_push    (rx_push),
    .dlab       (lctl_q[7]),
    .rx_cnt     (rx_count),
    .tx_cnt     (tx_count),
    .err_cnt    (err_cnt_q)
);

// File: tb/uart_fifo_regs_tb.sv
module uart_fifo_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_err_in = 1'b0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic [15:0] baud_div;
    logic [6:0]  frame_cfg;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    uart_fifo_regs u_dut (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_err_in(rx_err_in),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail),
        .baud_div(baud_div), .frame_cfg(frame_cfg)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        rd(a, d);
        check(tag, {8'h00, d}, {8'h00, exp});
    endtask

    task automatic push_rx(input logic [7:0] b, input logic e);
        @(negedge clk);
        rx_push = 1'b1; rx_byte = b; rx_err_in = e;
        @(negedge clk);
        rx_push = 1'b0; rx_err_in = 1'b0;
    endtask

    task automatic pop_tx(output logic [7:0] b);
        @(negedge clk);
        tx_pop = 1'b1;
        #1 b = tx_byte;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic test_reset;
        rd_chk(3'd5, 8'h20, "R1 line status");
        rd_chk(3'd2, 8'h01, "R1/R5 ident with FIFOs off");
        rd_chk(3'd3, 8'h00, "R1 line control");
        rd_chk(3'd1, 8'h00, "R1 interrupt enable");
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 divisor", baud_div, 16'h0000);
    endtask

    task automatic test_shared_addr;
        wr(3'd2, 8'hC7);
        rd_chk(3'd2, 8'hC1, "R2/R5 ident after control 0xC7");
        check("R5 irq none", {15'd0, irq}, 16'd0);
    endtask

    task automatic test_order;
        logic [7:0] b;
        wr(3'd2, 8'h07);
        push_rx(8'h11, 1'b0);
        push_rx(8'h22, 1'b0);
        push_rx(8'h33, 1'b0);
        rd_chk(3'd0, 8'h11, "R14 rx first");
        rd_chk(3'd0, 8'h22, "R14 rx second");
        rd_chk(3'd0, 8'h33, "R14 rx third");
        rd_chk(3'd0, 8'h00, "R14 rx empty read");
        wr(3'd0, 8'hA1);
        wr(3'd0, 8'hB2);
        check("R14 tx avail", {15'd0, tx_avail}, 16'd1);
        pop_tx(b); check("R14 tx first", {8'h00, b}, 16'h00A1);
        pop_tx(b); check("R14 tx second", {8'h00, b}, 16'h00B2);
        check("R14 tx drained", {15'd0, tx_avail}, 16'd0);
    endtask

    task automatic test_clear;
        push_rx(8'h01, 1'b0);
        push_rx(8'h02, 1'b0);
        wr(3'd0, 8'h55);
        wr(3'd0, 8'h55);
        rd_chk(3'd5, 8'h01, "R8 both queues occupied");
        wr(3'd2, 8'h01);
        rd_chk(3'd5, 8'h01, "R3 zero clear bits no effect");
        wr(3'd2, 8'h03);
        rd_chk(3'd5, 8'h00, "R3 rx cleared, R4 tx kept");
        wr(3'd2, 8'h05);
        rd_chk(3'd5, 8'h20, "R4 tx cleared");
        push_rx(8'h77, 1'b0);
        rd_chk(3'd5, 8'h21, "R3 self-cleared, later byte kept");
        rd_chk(3'd0, 8'h77, "R3 later byte data");
    endtask

    task automatic test_lsr_err;
        push_rx(8'h10, 1'b0);
        push_rx(8'h20, 1'b1);
        push_rx(8'h30, 1'b0);
        rd_chk(3'd5, 8'hA1, "R9 error held");
        rd_chk(3'd0, 8'h10, "R9 data 1");
        rd_chk(3'd5, 8'hA1, "R9 error still held");
        rd_chk(3'd0, 8'h20, "R9 data 2");
        rd_chk(3'd5, 8'h21, "R9 error gone");
        rd_chk(3'd0, 8'h30, "R9 data 3");
        rd_chk(3'd5, 8'h20, "R8 rx empty");
        push_rx(8'h40, 1'b1);
        rd_chk(3'd5, 8'hA1, "R9 error again");
        wr(3'd2, 8'h03);
        rd_chk(3'd5, 8'h20, "R9 clear drops error");
    endtask

    task automatic test_trigger;
        int levels [4] = '{8, 16, 56, 60};
        wr(3'd1, 8'h01);
        for (int code = 0; code < 4; code++) begin
            wr(3'd2, {code[1:0], 6'b000011});
            for (int i = 0; i < levels[code] - 1; i++) push_rx(i[7:0], 1'b0);
            rd_chk(3'd2, 8'hC1, $sformatf("R6 code %0d below level", code));
            check($sformatf("R6 code %0d irq low", code), {15'd0, irq}, 16'd0);
            push_rx(8'hFF, 1'b0);
            rd_chk(3'd2, 8'hC4, $sformatf("R6 code %0d at level", code));
            check($sformatf("R6 code %0d irq high", code), {15'd0, irq}, 16'd1);
        end
        wr(3'd2, 8'h07);
    endtask

    task automatic test_tx_int;
        wr(3'd1, 8'h03);
        rd_chk(3'd2, 8'hC2, "R7 tx empty pending");
        check("R7 irq tx", {15'd0, irq}, 16'd1);
        wr(3'd0, 8'h99);
        rd_chk(3'd2, 8'hC1, "R7 tx not empty");
        wr(3'd2, 8'h07);
        for (int i = 0; i < 8; i++) push_rx(i[7:0], 1'b0);
        rd_chk(3'd2, 8'hC4, "R7 rx wins over tx");
        wr(3'd1, 8'h02);
        rd_chk(3'd2, 8'hC2, "R7 rx masked");
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h07);
    endtask

    task automatic test_overrun;
        logic [7:0] d;
        int bad = 0;
        for (int i = 0; i < 64; i++) push_rx(i[7:0], 1'b0);
        push_rx(8'hEE, 1'b0);
        rd_chk(3'd5, 8'h23, "R10 overrun set");
        rd_chk(3'd5, 8'h21, "R10 overrun cleared by read");
        for (int i = 0; i < 64; i++) begin
            rd(3'd0, d);
            if (d !== i[7:0]) bad++;
        end
        check("R10/R14 64 bytes in order", bad[15:0], 16'd0);
        rd_chk(3'd0, 8'h00, "R10 extra byte dropped");
    endtask

    task automatic test_clear_priority;
        push_rx(8'h01, 1'b0);
        push_rx(8'h02, 1'b0);
        push_rx(8'h03, 1'b0);
        @(negedge clk);
        host_addr = 3'd2; host_wdata = 8'h03; host_wr = 1'b1;
        rx_push = 1'b1; rx_byte = 8'h5A; rx_err_in = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; rx_push = 1'b0; rx_err_in = 1'b0;
        rd_chk(3'd5, 8'h20, "R12 clear beats push");
        wr(3'd0, 8'h61);
        wr(3'd0, 8'h62);
        @(negedge clk);
        host_addr = 3'd2; host_wdata = 8'h05; host_wr = 1'b1; tx_pop = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; tx_pop = 1'b0;
        check("R12 clear beats pop", {15'd0, tx_avail}, 16'd0);
        rd_chk(3'd5, 8'h20, "R12 tx empty after clear");
    endtask

    task automatic test_dlab;
        wr(3'd1, 8'h02);
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd_chk(3'd0, 8'h34, "R11 divisor low");
        rd_chk(3'd1, 8'h12, "R11 divisor high");
        check("R11 baud_div", baud_div, 16'h1234);
        check("R11 no tx push", {15'd0, tx_avail}, 16'd0);
        rd_chk(3'd3, 8'h83, "R11 line control readback");
        wr(3'd3, 8'h03);
        rd_chk(3'd3, 8'h03, "R11 line control 8N1");
        check("R11 frame_cfg", {9'd0, frame_cfg}, 16'h0003);
        rd_chk(3'd1, 8'h02, "R11 enable kept");
        wr(3'd1, 8'h00);
    endtask

    task automatic test_non_fifo;
        logic [7:0] b;
        push_rx(8'h01, 1'b0);
        push_rx(8'h02, 1'b0);
        wr(3'd2, 8'h00);
        rd_chk(3'd5, 8'h20, "R13 disable clears");
        rd_chk(3'd2, 8'h01, "R13/R5 ident FIFOs off");
        push_rx(8'hA0, 1'b0);
        push_rx(8'hB0, 1'b0);
        rd_chk(3'd5, 8'h23, "R13 one-byte holding overrun");
        rd_chk(3'd0, 8'hA0, "R13 held byte");
        rd_chk(3'd0, 8'h00, "R13 second dropped");
        wr(3'd0, 8'h11);
        wr(3'd0, 8'h22);
        pop_tx(b); check("R13 tx held byte", {8'h00, b}, 16'h0011);
        check("R13 tx second dropped", {15'd0, tx_avail}, 16'd0);
        wr(3'd1, 8'h01);
        push_rx(8'hC0, 1'b0);
        rd_chk(3'd2, 8'h04, "R13 level one");
        check("R13 irq", {15'd0, irq}, 16'd1);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h01);
        rd_chk(3'd5, 8'h20, "R13 enable clears");
        rd_chk(3'd2, 8'hC1, "R5 ident FIFOs on");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset;
        test_shared_addr;
        test_order;
        test_clear;
        test_lsr_err;
        test_trigger;
        test_tx_int;
        test_overrun;
        test_clear_priority;
        test_dlab;
        test_non_fifo;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule